// File: doc/BRIEF.md
# Two-Stage SCL Rate Divider

This block produces the bit timing for an I2C bit engine from the peripheral clock. Two programmable prescalers run in cascade. A 2-bit stage divides by (A+1). Its carry feeds a 6-bit stage that divides by (B+1). Each carry out of the second stage is one timing tick. A phase sequencer counts eleven ticks with the SCL reference low and then eleven ticks with it high. One bit period therefore lasts 22·(A+1)·(B+1) input clocks. The fastest setting, with both fields at zero, gives one bit every 22 clocks.

The bit engine raises `run` to start clocking and drops it to stop. Four single-cycle strobes tell the engine when to act:
- the cycle before SCL falls;
- the point in the low phase where SDA may change;
- the cycle before SCL rises;
- the sample point in the high phase.

While the sequencer is in the high phase and the bus SCL line reads low, a slave is stretching the clock, and all counting pauses. The divider fields are copied into shadow registers on every clock where `run` is low. A write to the fields during a transfer therefore cannot disturb a running bit.

States of the sequencer:
- IDLE: reference high, counters cleared.
- LOW: reference low.
- HIGH: reference released high.

Transitions:
- IDLE→LOW when `run` is seen high.
- LOW→HIGH on the eleventh tick of the low phase.
- HIGH→LOW on the eleventh tick of the high phase.
- Any state→IDLE when `run` is low.

Top module: `scl_rate_gen`

## Requirements
- R1: While `run` is low the block sits in IDLE with `scl_ref` = 1. From the cycle after `run` is first sampled low, `scl_ref` is 1 and `phase_stb` is 0.
- R2: With `run` held high and no stretching, consecutive fall strobes are exactly 22·P clocks apart, where P = (A+1)·(B+1).
- R3: `div_a` is a 2-bit field giving factors 1 to 4, and `div_b` is a 6-bit field giving factors 1 to 64. With both at zero the bit period is 22 clocks.
- R4: The fall strobe (`phase_stb` bit 0) is asserted in two cases: in the IDLE cycle where `run` is high, and on the last tick of every high phase. `scl_ref` is 0 from the next cycle.
- R5: The change strobe (`phase_stb` bit 1) is asserted in clock 5·P of each low phase, counting the first low clock as 1.
- R6: The rise strobe (`phase_stb` bit 2) is asserted in the last clock (11·P) of each low phase. `scl_ref` is 1 from the next cycle.
- R7: The sample strobe (`phase_stb` bit 3) is asserted in clock 5·P of each high phase.
- R8: Each clock spent in HIGH with `scl_in` low freezes all counters, so the high phase grows by exactly one clock. `scl_in` is ignored in LOW.
- R9: The divider fields are captured on each clock edge where `run` is low. Changes made while `run` is high have no effect until the next idle period.
- R10: At most one bit of `phase_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_a | input | 2 | First prescaler field, factor div_a+1 |
| div_b | input | 6 | Second prescaler field, factor div_b+1 |
| run | input | 1 | Clocking request from the bit engine |
| scl_in | input | 1 | Sensed level of the bus SCL line |
| scl_ref | output | 1 | SCL reference: 0 drive low, 1 release |
| phase_stb | output | 4 | Strobes: bit0 fall, bit1 SDA change, bit2 rise, bit3 sample |

## Verification
The assertions take for granted that `scl_in` follows the wired-AND of the block's own reference and any slave pull-down. They also assume that `run` changes only between clock edges, and that the divider fields stay steady across the edge where `run` rises. The bench models the bus exactly that way: `scl_in` is `scl_ref` ANDed with a stretch request. It drives `run` and the fields only on falling clock edges and holds the fields for several idle cycles before each start. Random prescaler settings drawn from a fixed seed are mixed with the fastest and slowest settings, a stretch during a high phase, and a field change while running.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam int STB_FALL = 0;
    localparam int STB_CHG  = 1;
    localparam int STB_RISE = 2;
    localparam int STB_SMP  = 3;
    localparam int STB_N    = 4;

endpackage

// File: rtl/scl_div_shadow.sv
`timescale 1ns/1ps
module scl_div_shadow #(
    parameter int A_W = 2,
    parameter int B_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [A_W-1:0] a_sh,
    output logic [B_W-1:0] b_sh
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_sh <= '0;
        end else if (!run) begin
            a_sh <= a_in;
            b_sh <= b_in;
        end
    end

    // A running bit never sees a new divider value.
    assert_shadow_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(a_sh) && $stable(b_sh)));

endmodule

// File: rtl/scl_div_stage.sv
`timescale 1ns/1ps
module scl_div_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic         carry
);

    logic [W-1:0] cnt;

    assign carry = en && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || carry) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= lim));

endmodule

// File: rtl/scl_div_seq.sv
`timescale 1ns/1ps
module scl_div_seq
    import scl_div_pkg::*;
#(
    parameter int HALF_TICKS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             scl_in,
    output logic             idle,
    output logic             cnt_en,
    output logic             scl_ref,
    output logic [STB_N-1:0] stb
);

    localparam int TW       = $clog2(HALF_TICKS);
    localparam int LAST_T   = HALF_TICKS - 1;
    localparam int MID_T    = HALF_TICKS / 2 - 1;

    phase_e        state, state_n;
    logic [TW-1:0] tcnt;
    logic          hold;
    logic          last_tick;
    logic          mid_tick;

    assign last_tick = tick && (tcnt == TW'(LAST_T));
    assign mid_tick  = tick && (tcnt == TW'(MID_T));
    assign hold      = (state == PH_HIGH) && !scl_in;
    assign idle      = (state == PH_IDLE);
    assign cnt_en    = !idle && !hold;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            PH_IDLE: if (run) state_n = PH_LOW;
            PH_LOW: begin
                if (!run)           state_n = PH_IDLE;
                else if (last_tick) state_n = PH_HIGH;
            end
            PH_HIGH: begin
                if (!run)           state_n = PH_IDLE;
                else if (last_tick) state_n = PH_LOW;
            end
            default: state_n = PH_IDLE;
        endcase
    end

    // Tick counter within a phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (!run || idle || last_tick) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        stb     = '0;
        scl_ref = 1'b1;
        unique case (state)
            PH_IDLE: stb[STB_FALL] = run;
            PH_LOW: begin
                scl_ref       = 1'b0;
                stb[STB_CHG]  = run && mid_tick;
                stb[STB_RISE] = run && last_tick;
            end
            PH_HIGH: begin
                stb[STB_SMP]  = run && mid_tick;
                stb[STB_FALL] = run && last_tick;
            end
            default: stb = '0;
        endcase
    end

    assert_idle_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> scl_ref);

    assert_fall_then_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb[STB_FALL] |=> !scl_ref);

    assert_rise_then_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb[STB_RISE] |=> scl_ref);

    assert_stretch_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && run) |=> $stable(tcnt));

    assert_stb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

endmodule

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter int A_W        = 2,
    parameter int B_W        = 6,
    parameter int HALF_TICKS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [A_W-1:0]   div_a,
    input  logic [B_W-1:0]   div_b,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_ref,
    output logic [STB_N-1:0] phase_stb
);

    logic [A_W-1:0] a_sh;
    logic [B_W-1:0] b_sh;
    logic           idle;
    logic           cnt_en;
    logic           carry_a;
    logic           tick;

    scl_div_shadow #(.A_W(A_W), .B_W(B_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .a_in  (div_a),
        .b_in  (div_b),
        .a_sh  (a_sh),
        .b_sh  (b_sh)
    );

    scl_div_stage #(.W(A_W)) u_stage_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle),
        .en    (cnt_en),
        .lim   (a_sh),
        .carry (carry_a)
    );

    scl_div_stage #(.W(B_W)) u_stage_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle),
        .en    (carry_a),
        .lim   (b_sh),
        .carry (tick)
    );

    scl_div_seq #(.HALF_TICKS(HALF_TICKS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .scl_in  (scl_in),
        .idle    (idle),
        .cnt_en  (cnt_en),
        .scl_ref (scl_ref),
        .stb     (phase_stb)
    );

endmodule

// File: tb/sim_scl_rate_gen.sv
`timescale 1ns/1ps
module sim_scl_rate_gen;

    localparam int S_FALL = 0;
    localparam int S_CHG  = 1;
    localparam int S_RISE = 2;
    localparam int S_SMP  = 3;
    localparam int LIMIT  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       run = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_ref;
    logic [3:0] phase_stb;

    int n_chk  = 0;
    int n_fail = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Wired-AND bus model: the slave may only pull SCL low.
    assign scl_in = scl_ref & ~stretch;

    scl_rate_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_a     (div_a),
        .div_b     (div_b),
        .run       (run),
        .scl_in    (scl_in),
        .scl_ref   (scl_ref),
        .phase_stb (phase_stb)
    );

    function automatic int prod(input int a, input int b);
        return (a + 1) * (b + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_stb(input int idx, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if ($countones(phase_stb) > 1) overlap++;
        end while (!phase_stb[idx] && n < LIMIT);
    endtask

    task automatic run_cfg(input int a, input int b);
        int p, n;
        p = prod(a, b);
        run = 1'b0;
        div_a = 2'(a);
        div_b = 6'(b);
        repeat (3) @(negedge clk);
        check(scl_ref == 1'b1 && phase_stb == 4'b0, "R1 idle outputs", {scl_ref, phase_stb}, 16);
        run = 1'b1;
        #1;
        check(phase_stb == 4'b0001, "R4 fall strobe at start", phase_stb, 1);
        wait_stb(S_CHG, n);
        check(n == 5 * p, "R5 change point", n, 5 * p);
        check(scl_ref == 1'b0, "R5 ref low at change", scl_ref, 0);
        wait_stb(S_RISE, n);
        check(n == 6 * p, "R6 rise point", n, 6 * p);
        wait_stb(S_SMP, n);
        check(n == 5 * p, "R7 sample point", n, 5 * p);
        check(scl_ref == 1'b1, "R7 ref high at sample", scl_ref, 1);
        wait_stb(S_FALL, n);
        check(n == 6 * p, "R4 fall at end of high", n, 6 * p);
        wait_stb(S_FALL, n);
        check(n == 22 * p, "R2 R3 full bit period", n, 22 * p);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(scl_ref == 1'b1 && phase_stb == 4'b0, "R1 stop returns idle", {scl_ref, phase_stb}, 16);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n, m, p;
        void'($urandom(32'h1c5e_ed01));
        repeat (3) @(negedge clk);
        check(scl_ref == 1'b1 && phase_stb == 4'b0, "R1 reset state", {scl_ref, phase_stb}, 16);
        rst_n = 1'b1;
        @(negedge clk);

        // Corners: fastest and slowest settings (R3)
        run_cfg(0, 0);
        run_cfg(3, 63);
        run_cfg(3, 0);
        run_cfg(0, 63);

        // Random settings
        for (int i = 0; i < 5; i++) begin
            run_cfg(int'($urandom % 4), int'($urandom % 16));
        end

        // R9: field change while running is ignored until idle
        div_a = 2'd1;
        div_b = 6'd2;
        p = prod(1, 2);
        repeat (3) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        div_a = 2'd3;
        div_b = 6'd9;
        wait_stb(S_FALL, n);
        check(n + 1 == 22 * p, "R9 running bit keeps old divider", n + 1, 22 * p);
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        run = 1'b1;
        wait_stb(S_CHG, n);
        check(n == 5 * prod(3, 9), "R9 new divider after idle", n, 5 * prod(3, 9));
        @(negedge clk);
        run = 1'b0;

        // R8: stretching during the high phase
        div_a = 2'd0;
        div_b = 6'd1;
        p = prod(0, 1);
        repeat (3) @(negedge clk);
        run = 1'b1;
        wait_stb(S_RISE, n);
        @(negedge clk);
        stretch = 1'b1;
        repeat (7) @(negedge clk);
        check(scl_ref == 1'b1, "R8 ref released while stretched", scl_ref, 1);
        stretch = 1'b0;
        wait_stb(S_FALL, m);
        check(m + 8 == 11 * p + 7, "R8 high phase lengthened", m + 8, 11 * p + 7);
        wait_stb(S_FALL, n);
        check(n == 22 * p, "R8 period restored after stretch", n, 22 * p);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);

        check(overlap == 0, "R10 strobes never overlap", overlap, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule